// File: doc/BRIEF.md
# Redundant and Zero Switching-State Resolver

This block sits between a vector-based hysteresis current controller and the gate logic of a three-rail, three-level converter leg set. The controller asks for a switching vector. The block turns that request into a concrete phase-state word in which each of the three phases is tied to rail A, B or C. Levels rise from A through B to C.

Two kinds of request leave a choice open, and the block settles both. A zero request can be met by AAA, BBB or CCC. The block picks the rail that the last applied active vector already used on most phases, so that as few phases as possible move. An inner-hexagon request can be met by two states that differ by one level on every phase: the lower member uses only rails A and B, and the upper member uses only B and C. One member charges one capacitor and discharges the other, and the second member does the reverse. A balance flag picks the member. The flag changes state on a capacitor sample strobe whenever either capacitor voltage lies outside its tolerance band around the half-bus reference. Outer-hexagon requests apply the whole bus, so they pass through unchanged.

The active-vector memory is a three-state machine. MEM_EMPTY is the state after reset, when no active vector has been applied yet. MEM_ACTIVE means the last applied request was active. MEM_ZEROED means a zero was applied after an active vector. The transitions are:
- load_first: MEM_EMPTY to MEM_ACTIVE.
- go_zero: MEM_ACTIVE to MEM_ZEROED.
- reload: MEM_ACTIVE or MEM_ZEROED to MEM_ACTIVE.
- stay: every other case, including zero requests in MEM_EMPTY or MEM_ZEROED.

Top module: `vector_state_selector`

## Requirements
- R1: After reset, phase_out is AAA (all zero) and the balance flag selects the lower inner member.
- R2: Encoding is A=00, B=01, C=10, with 11 illegal. Phase a sits in bits [1:0], phase b in [3:2] and phase c in [5:4]. phase_out takes its new value on the clock edge that samples req_valid high, and it holds while req_valid is low.
- R3: A non-zero request that is legal and not inner passes through unchanged. This covers outer words that span A to C and constant words. A constant word sent with req_zero low does not change the active-vector memory.
- R4: A zero request after an active vector that has a repeated rail gives that rail on all three phases. For example, AAB, ABA and BAA give AAA, and BAB gives BBB.
- R5: A zero request after an active vector whose three rails are all different gives the rail of phase a on all phases.
- R6: A zero request before any active vector gives AAA. Zero requests never change the active-vector memory.
- R7: An inner request, meaning a word whose levels differ by exactly one, gives the lower (A/B) member of its pair when the flag is 0 and the upper (B/C) member when the flag is 1. Either member may be sent as the request.
- R8: On a clock edge with cap_stb high, the flag toggles if either capacitor voltage is below CAP_REF-CAP_TOL or above CAP_REF+CAP_TOL. Both limits count as inside the band. The flag does not change without cap_stb.
- R9: A non-zero request that contains an illegal 11 field gives AAA and leaves the active-vector memory unchanged.
- R10: When req_zero is high, req_code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_zero | input | 1 | Request is a zero vector |
| req_code | input | 6 | Requested phase-state word |
| cap_stb | input | 1 | Capacitor samples valid |
| cap1_v | input | VW | Upper capacitor voltage sample |
| cap2_v | input | VW | Lower capacitor voltage sample |
| phase_out | output | 6 | Registered applied phase-state word |

## Verification
Several properties are checked on every cycle by assertions. The output never carries an illegal field. The output holds between requests. Outer and constant words pass through. Illegal requests give AAA. Zero requests give a uniform word. Inner requests give an inner word. The flag keeps its value unless a strobe arrives with a band violation.

Some behaviour can only be shown by the bench scenarios, because it depends on history. These are: which rail a zero picks after a given active vector, the AAA result before any active vector, memory that survives illegal and constant requests, the choice of member after a chain of strobes, and the exact band limits.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    localparam int NPH   = 3;
    localparam int WORDW = 2 * NPH;

    typedef enum logic [1:0] {
        RAIL_A   = 2'b00,
        RAIL_B   = 2'b01,
        RAIL_C   = 2'b10,
        RAIL_BAD = 2'b11
    } rail_e;

    typedef enum logic [1:0] {
        VK_ZERO,
        VK_INNER,
        VK_OUTER,
        VK_ILLEGAL
    } vkind_e;

    typedef enum logic [1:0] {
        MEM_EMPTY,
        MEM_ACTIVE,
        MEM_ZEROED
    } mem_e;

    // Sort a phase word into zero, inner, outer or illegal by its level span.
    function automatic vkind_e classify(input logic [WORDW-1:0] w);
        logic [1:0] mn;
        logic [1:0] mx;
        logic       bad;
        vkind_e     k;
        mn  = 2'd2;
        mx  = 2'd0;
        bad = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            if (w[2*i +: 2] == RAIL_BAD) bad = 1'b1;
            else begin
                if (w[2*i +: 2] < mn) mn = w[2*i +: 2];
                if (w[2*i +: 2] > mx) mx = w[2*i +: 2];
            end
        end
        if (bad)                  k = VK_ILLEGAL;
        else if (mx == mn)        k = VK_ZERO;
        else if (mx - mn == 2'd1) k = VK_INNER;
        else                      k = VK_OUTER;
        return k;
    endfunction

    // Pick one member of an inner redundant pair: hi=0 gives A/B, hi=1 gives B/C.
    function automatic logic [WORDW-1:0] inner_member(input logic [WORDW-1:0] w,
                                                      input logic hi);
        logic              has_c;
        logic [WORDW-1:0]  r;
        has_c = 1'b0;
        for (int i = 0; i < NPH; i++)
            if (w[2*i +: 2] == RAIL_C) has_c = 1'b1;
        for (int i = 0; i < NPH; i++) begin
            r[2*i +: 2] = w[2*i +: 2];
            if (has_c && !hi)      r[2*i +: 2] = w[2*i +: 2] - 2'd1;
            else if (!has_c && hi) r[2*i +: 2] = w[2*i +: 2] + 2'd1;
        end
        return r;
    endfunction

    // Rail used by most phases; phase a wins when all three differ.
    function automatic logic [1:0] zero_rail(input logic [WORDW-1:0] w);
        logic [1:0] pa;
        logic [1:0] pb;
        logic [1:0] pc;
        pa = w[1:0];
        pb = w[3:2];
        pc = w[5:4];
        if (pa == pb || pa == pc) return pa;
        if (pb == pc)             return pb;
        return pa;
    endfunction

    function automatic logic [WORDW-1:0] uniform_word(input logic [1:0] r);
        return {NPH{r}};
    endfunction

endpackage

// File: rtl/vsel_balance.sv
module vsel_balance #(
    parameter int VW      = 12,
    parameter int CAP_REF = 2048,
    parameter int CAP_TOL = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_stb,
    input  logic [VW-1:0] cap1_v,
    input  logic [VW-1:0] cap2_v,
    output logic          pair_hi
);
    localparam logic [VW:0] LIM_HI = (VW+1)'(CAP_REF + CAP_TOL);
    localparam logic [VW:0] LIM_LO = (VW+1)'(CAP_REF - CAP_TOL);

    logic [VW:0] v1_ext;
    logic [VW:0] v2_ext;
    logic        off_band;

    always_comb begin
        v1_ext   = {1'b0, cap1_v};
        v2_ext   = {1'b0, cap2_v};
        off_band = (v1_ext > LIM_HI) || (v1_ext < LIM_LO) ||
                   (v2_ext > LIM_HI) || (v2_ext < LIM_LO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    pair_hi <= 1'b0;
        else if (cap_stb && off_band)  pair_hi <= ~pair_hi;
    end

    // R8: no strobe, no change
    a_r8_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(pair_hi));

    // R8: both samples inside band keep the flag
    a_r8_in_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && {1'b0, cap1_v} <= LIM_HI && {1'b0, cap1_v} >= LIM_LO &&
         {1'b0, cap2_v} <= LIM_HI && {1'b0, cap2_v} >= LIM_LO) |=> $stable(pair_hi));

endmodule

// File: rtl/vsel_zero_track.sv
module vsel_zero_track
    import vsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_load,
    input  logic [WORDW-1:0] act_word,
    input  logic             zero_apply,
    output logic [WORDW-1:0] zero_word,
    output mem_e             mem_state
);
    mem_e             mem_q;
    mem_e             mem_d;
    logic [WORDW-1:0] last_q;

    // State register and active-vector memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q  <= MEM_EMPTY;
            last_q <= '0;
        end else begin
            mem_q <= mem_d;
            if (act_load) last_q <= act_word;
        end
    end

    // Next-state logic
    always_comb begin
        mem_d = mem_q;
        unique case (mem_q)
            MEM_EMPTY:  if (act_load) mem_d = MEM_ACTIVE;
            MEM_ACTIVE: if (act_load) mem_d = MEM_ACTIVE;
                        else if (zero_apply) mem_d = MEM_ZEROED;
            MEM_ZEROED: if (act_load) mem_d = MEM_ACTIVE;
            default:    mem_d = MEM_EMPTY;
        endcase
    end

    // Output process
    always_comb begin
        unique case (mem_q)
            MEM_EMPTY: zero_word = uniform_word(RAIL_A);
            default:   zero_word = uniform_word(zero_rail(last_q));
        endcase
        mem_state = mem_q;
    end

    // R6: a zero request alone never leaves the empty state
    a_r6_zero_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_q == MEM_EMPTY && !act_load) |=> mem_q == MEM_EMPTY);

endmodule

// File: rtl/vector_state_selector.sv
module vector_state_selector
    import vsel_pkg::*;
#(
    parameter int VW      = 12,
    parameter int CAP_REF = 2048,
    parameter int CAP_TOL = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_zero,
    input  logic [5:0]    req_code,
    input  logic          cap_stb,
    input  logic [VW-1:0] cap1_v,
    input  logic [VW-1:0] cap2_v,
    output logic [5:0]    phase_out
);
    vkind_e           req_kind;
    logic             pair_hi;
    logic             act_load;
    logic             zero_apply;
    logic [WORDW-1:0] zero_word;
    logic [WORDW-1:0] next_word;
    mem_e             mem_state;

    vsel_balance #(
        .VW      (VW),
        .CAP_REF (CAP_REF),
        .CAP_TOL (CAP_TOL)
    ) u_balance (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_stb (cap_stb),
        .cap1_v  (cap1_v),
        .cap2_v  (cap2_v),
        .pair_hi (pair_hi)
    );

    vsel_zero_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_load   (act_load),
        .act_word   (next_word),
        .zero_apply (zero_apply),
        .zero_word  (zero_word),
        .mem_state  (mem_state)
    );

    always_comb begin
        req_kind   = classify(req_code);
        zero_apply = req_valid && req_zero;
        act_load   = req_valid && !req_zero &&
                     (req_kind == VK_INNER || req_kind == VK_OUTER);
        if (req_zero) begin
            next_word = zero_word;
        end else begin
            unique case (req_kind)
                VK_INNER:   next_word = inner_member(req_code, pair_hi);
                VK_ILLEGAL: next_word = uniform_word(RAIL_A);
                default:    next_word = req_code;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         phase_out <= '0;
        else if (req_valid) phase_out <= next_word;
    end

    // R2: output holds without a request
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(phase_out));

    // R2: output is always a legal word
    a_r2_out_legal: assert property (@(posedge clk) disable iff (!rst_n)
        classify(phase_out) != VK_ILLEGAL);

    // R3: outer and constant non-zero requests pass through
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_zero && (req_kind == VK_OUTER || req_kind == VK_ZERO))
        |=> phase_out == $past(req_code));

    // R9: illegal request forces AAA
    a_r9_illegal_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_zero && req_kind == VK_ILLEGAL) |=> phase_out == '0);

    // R4: zero request yields a uniform word
    a_r4_zero_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        zero_apply |=> (phase_out[1:0] == phase_out[3:2] && phase_out[3:2] == phase_out[5:4]));

    // R7: inner request yields an inner word
    a_r7_inner_member: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_zero && req_kind == VK_INNER) |=> classify(phase_out) == VK_INNER);

    // R6: before any active vector a zero request gives AAA
    a_r6_empty_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_apply && mem_state == MEM_EMPTY) |=> phase_out == '0);

endmodule

// File: tb/vector_state_selector_bench.sv
module vector_state_selector_bench;

    localparam int VW  = 12;
    localparam int REF = 2048;
    localparam int TOL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_zero = 1'b0;
    logic [5:0]    req_code = '0;
    logic          cap_stb = 1'b0;
    logic [VW-1:0] cap1_v = 12'(REF);
    logic [VW-1:0] cap2_v = 12'(REF);
    logic [5:0]    phase_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] w;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // bench model
    bit         m_has  = 1'b0;
    logic [5:0] m_last = '0;
    bit         m_flag = 1'b0;
    logic [5:0] m_out  = '0;

    always #10 clk = ~clk;

    vector_state_selector #(.VW(VW), .CAP_REF(REF), .CAP_TOL(TOL)) u_vector_state_selector (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_zero  (req_zero),
        .req_code  (req_code),
        .cap_stb   (cap_stb),
        .cap1_v    (cap1_v),
        .cap2_v    (cap2_v),
        .phase_out (phase_out)
    );

    function automatic bit has_rail(input logic [5:0] w, input logic [1:0] r);
        return (w[1:0] == r) || (w[3:2] == r) || (w[5:4] == r);
    endfunction

    function automatic logic [5:0] model(input bit z, input logic [5:0] c);
        logic [5:0] r;
        bit illegal;
        bit inner;
        bit outer;
        illegal = has_rail(c, 2'b11);
        outer   = has_rail(c, 2'b00) && has_rail(c, 2'b10);
        inner   = !illegal && !outer && (c[1:0] != c[3:2] || c[3:2] != c[5:4]);
        if (z) begin
            if (!m_has) r = 6'b000000;
            else if (m_last[3:2] == m_last[5:4] && m_last[1:0] != m_last[3:2])
                r = {3{m_last[3:2]}};
            else r = {3{m_last[1:0]}};
        end else if (illegal) begin
            r = 6'b000000;
        end else if (inner) begin
            if (has_rail(c, 2'b10)) r = m_flag ? c : c - 6'b010101;
            else                    r = m_flag ? c + 6'b010101 : c;
            m_has = 1'b1;
            m_last = r;
        end else begin
            r = c;
            if (outer) begin
                m_has = 1'b1;
                m_last = r;
            end
        end
        return r;
    endfunction

    task automatic check(input logic [5:0] got, input logic [5:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic send(input bit z, input logic [5:0] c, input string tag);
        exp_t e;
        e.w   = model(z, c);
        e.tag = tag;
        m_out = e.w;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1;
        req_zero  = z;
        req_code  = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic strobe(input int v1, input int v2);
        if (v1 > REF + TOL || v1 < REF - TOL || v2 > REF + TOL || v2 < REF - TOL)
            m_flag = !m_flag;
        @(negedge clk);
        cap1_v  = 12'(v1);
        cap2_v  = 12'(v2);
        cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0;
    endtask

    // monitor: pops one expected item per accepted request
    initial begin
        forever begin
            @(posedge clk);
            if (req_valid === 1'b1) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2 unexpected result got %b exp none", phase_out);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(phase_out, e.w, e.tag);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got hang exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase_out, 6'b000000, "R1 reset output AAA");

        send(1'b1, 6'b101010, "R6 R10 zero before active gives AAA");
        send(1'b1, 6'b011001, "R6 R10 zero again still AAA");
        send(1'b0, 6'b100000, "R3 outer AAC passes");
        send(1'b1, 6'b000000, "R4 zero after AAC gives AAA");
        send(1'b0, 6'b010001, "R1 R7 inner BAB flag0 low member");
        send(1'b1, 6'b000000, "R4 zero after BAB gives BBB");
        send(1'b1, 6'b000000, "R6 repeated zero keeps BBB");
        send(1'b0, 6'b100110, "R7 upper member CBC requested flag0 gives BAB");

        strobe(REF + TOL, REF - TOL);
        send(1'b0, 6'b010001, "R8 band edges inside no toggle");
        strobe(REF + TOL + 1, REF);
        send(1'b0, 6'b010001, "R7 R8 above band toggles to upper CBC");
        send(1'b1, 6'b000000, "R4 zero after CBC gives CCC");
        strobe(REF, REF - TOL - 1);
        send(1'b0, 6'b100110, "R8 below band toggles back to low BAB");

        // out of band values without a strobe
        @(negedge clk);
        cap1_v = 12'(REF + 500);
        cap2_v = 12'(REF - 500);
        repeat (4) @(negedge clk);
        send(1'b0, 6'b000100, "R8 no strobe no toggle inner AAB? low");

        send(1'b0, 6'b010010, "R3 distinct CAB passes");
        send(1'b1, 6'b000000, "R5 zero after CAB gives phase a rail CCC");
        send(1'b0, 6'b001100, "R9 illegal field gives AAA");
        send(1'b1, 6'b000000, "R9 memory unchanged after illegal");
        send(1'b0, 6'b010101, "R3 constant BBB passes");
        send(1'b1, 6'b000000, "R3 constant keeps memory CCC");
        send(1'b0, 6'b100001, "R5 distinct BAC passes");
        send(1'b1, 6'b111111, "R5 R10 zero after BAC gives BBB");

        repeat (5) @(negedge clk);
        check(phase_out, m_out, "R2 output holds without request");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule